// File: doc/BRIEF.md
# Six-Channel ADPCM Sample Sequencer

This block sequences six ADPCM sample voices. A host writes bytes into a small register file. Those bytes set a per-voice start address, end address, pan and level, and a global mix level. A write to the command register starts or stops any subset of the voices through a six-bit mask.

Each running voice walks sample memory one byte at a time. A byte carries two 4-bit codes. Each code moves a signed 12-bit accumulator by an adaptive step and then adjusts the step index. The accumulator is scaled by the voice level and gated by the pan bits to give a per-voice stereo pair. The six pairs are summed and scaled by the global level.

The memory port is a plain request/address pair. The byte returns on `mem_data` in the cycle after the request. Voices are served round robin. Each voice gets a two-cycle slot, so a full round of all six voices takes twelve cycles.

Top module: `adpcm_voice_seq`

## Requirements
- R1: After reset no voice plays, `mem_req` is low, and every per-voice and mixed output is zero.
- R2: The register file decodes only these addresses. Address 0x01 bits 5:0 hold the global level. Address 0x08+v holds pan-left (bit 7), pan-right (bit 6) and level (bits 4:0) for voice v. The start address is {0x18+v, 0x10+v}. The end address is {0x28+v, 0x20+v}. Voice v runs 0 to 5. Writes to any other address, such as 0x0E, 0x16 or 0x30 and above, change nothing.
- R3: A write to 0x00 with bit 7 clear starts every voice whose bit is set in bits 5:0. From the next cycle that voice plays, with its address at start<<SHIFT, its accumulator at 0, its step index at 0 and the high code pending.
- R4: A write to 0x00 with bit 7 set stops the masked voices from the next cycle. Their accumulators, and therefore their outputs, hold.
- R5: Slots run in voice order 0 to 5, two cycles each. In the first cycle of a slot, `mem_req` is high exactly when the voice plays and its high code is pending. The second cycle consumes `mem_data`. `mem_req` is never high two cycles running.
- R6: The high code (bits 7:4) of a byte is decoded first, in the fetch slot. The low code (bits 3:0) is decoded one slot later from the stored byte. The address increments only after the low code.
- R7: After the low code of the byte at ((end+1)<<SHIFT)-1, the voice stops instead of incrementing.
- R8: Code c has sign c[3] and magnitude m=c[2:0]. The step is (4 + idx[1:0]) << idx[3:2]. The accumulator moves by (step*(2m+1))>>3, downward when the sign is 1. The index moves by -1 for m<4 and by 2(m-3) otherwise.
- R9: The accumulator saturates to -2048..2047, and the step index saturates to 0..15.
- R10: A voice's left (right) output is (acc*level)>>>5 when its pan-left (pan-right) bit is 1, and zero otherwise.
- R11: Each mixed side is (sum of the six voice outputs on that side * global level)>>>6.
- R12: A command that addresses a voice takes effect over that voice's decode in the same cycle. If a command addresses a voice in the first cycle of its slot, that slot decodes nothing for the voice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 8 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16+SHIFT | Memory byte address |
| mem_data | input | 8 | Read byte, valid the cycle after `mem_req` |
| chan_playing | output | 6 | Per-voice playing flags |
| chan_left | output | 72 | Six signed 12-bit left outputs, voice v at bits 12v+11:12v |
| chan_right | output | 72 | Six signed 12-bit right outputs |
| mix_left | output | 15 | Signed mixed left output |
| mix_right | output | 15 | Signed mixed right output |

## Verification
A wrong address or code pointer shows up first on `mem_addr`, at the next fetch slot of that voice, which is at most twelve cycles away. A wrong accumulator or step index shows on that voice's outputs in the cycle after the faulty decode. It keeps diverging on every later decode, because each delta depends on the index. A missed end or stop shows on `chan_playing` and as an extra `mem_req` within one round. The bench therefore compares every port against a behavioural model on every clock.

// File: rtl/adpcm_voice_seq.sv
module adpcm_voice_seq #(
  parameter int SHIFT = 8,
  localparam int NCH = 6,
  localparam int AW = 16 + SHIFT,
  localparam int OW = 12,
  localparam int MW = OW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic [7:0]        mem_data,
  output logic [NCH-1:0]    chan_playing,
  output logic [NCH*OW-1:0] chan_left,
  output logic [NCH*OW-1:0] chan_right,
  output logic [MW-1:0]     mix_left,
  output logic [MW-1:0]     mix_right
);

  logic [NCH-1:0] playing, nib;
  logic [7:0] dbyte [NCH];
  logic [AW-1:0] addr [NCH];
  logic signed [OW-1:0] acc [NCH];
  logic [3:0] sidx [NCH];
  logic [7:0] chcfg [NCH];
  logic [15:0] sreg [NCH];
  logic [15:0] ereg [NCH];
  logic [5:0] total_lvl;
  logic [2:0] ch;
  logic ph, fetched;

  wire cmd_wr = wr_en && wr_addr == 6'h00;
  wire [NCH-1:0] cmd_mask = cmd_wr ? wr_data[5:0] : '0;
  wire hit = cmd_mask[ch];
  wire vsel = wr_addr[2:0] < 3'd6;

  assign mem_req = !ph && playing[ch] && !nib[ch];
  assign mem_addr = addr[ch];
  assign chan_playing = playing;

  wire go = ph && playing[ch] && (nib[ch] || fetched);
  wire [3:0] code = nib[ch] ? dbyte[ch][3:0] : mem_data[7:4];
  wire [3:0] cur_idx = sidx[ch];
  wire [6:0] step = 7'({3'b001, cur_idx[1:0]} << cur_idx[3:2]);
  wire [10:0] prod = 11'(step * {code[2:0], 1'b1});
  wire [7:0] delta = prod[10:3];
  wire signed [13:0] acc_ext = acc[ch];
  wire signed [13:0] dl = $signed({6'b0, delta});
  wire signed [13:0] acc_sum = code[3] ? acc_ext - dl : acc_ext + dl;
  wire signed [OW-1:0] acc_new = acc_sum > 14'sd2047 ? 12'sd2047 :
                                 acc_sum < -14'sd2048 ? -12'sd2048 : acc_sum[OW-1:0];
  wire signed [5:0] adj = code[2] ? 6'sd2 + $signed({3'b0, code[1:0], 1'b0}) : -6'sd1;
  wire signed [5:0] idx_sum = $signed({2'b0, cur_idx}) + adj;
  wire [3:0] idx_new = idx_sum < 0 ? 4'd0 : idx_sum > 6'sd15 ? 4'd15 : idx_sum[3:0];
  wire [AW-1:0] last = {ereg[ch], {SHIFT{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0;
      ch <= '0;
      fetched <= 1'b0;
      playing <= '0;
      nib <= '0;
      total_lvl <= '0;
      for (int i = 0; i < NCH; i++) begin
        dbyte[i] <= '0;
        addr[i] <= '0;
        acc[i] <= '0;
        sidx[i] <= '0;
        chcfg[i] <= '0;
        sreg[i] <= '0;
        ereg[i] <= '0;
      end
    end else begin
      ph <= !ph;
      if (ph) ch <= (ch == 3'(NCH - 1)) ? 3'd0 : ch + 3'd1;
      fetched <= mem_req && !hit;
      if (go) begin
        acc[ch] <= acc_new;
        sidx[ch] <= idx_new;
        if (!nib[ch]) begin
          dbyte[ch] <= mem_data;
          nib[ch] <= 1'b1;
        end else begin
          nib[ch] <= 1'b0;
          if (addr[ch] == last) playing[ch] <= 1'b0;
          else addr[ch] <= addr[ch] + 1'b1;
        end
      end
      if (wr_en) begin
        case (wr_addr[5:3])
          3'd0: if (wr_addr[2:0] == 3'd1) total_lvl <= wr_data[5:0];
          3'd1: if (vsel) chcfg[wr_addr[2:0]] <= wr_data;
          3'd2: if (vsel) sreg[wr_addr[2:0]][7:0] <= wr_data;
          3'd3: if (vsel) sreg[wr_addr[2:0]][15:8] <= wr_data;
          3'd4: if (vsel) ereg[wr_addr[2:0]][7:0] <= wr_data;
          3'd5: if (vsel) ereg[wr_addr[2:0]][15:8] <= wr_data;
          default: ;
        endcase
      end
      for (int i = 0; i < NCH; i++) begin
        if (cmd_mask[i]) begin
          if (wr_data[7]) begin
            playing[i] <= 1'b0;
          end else begin
            playing[i] <= 1'b1;
            nib[i] <= 1'b0;
            acc[i] <= '0;
            sidx[i] <= '0;
            addr[i] <= {sreg[i], {SHIFT{1'b0}}};
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    wire signed [17:0] scaled = acc[g] * $signed({1'b0, chcfg[g][4:0]});
    wire signed [17:0] shr = scaled >>> 5;
    assign chan_left[g*OW +: OW]  = chcfg[g][7] ? shr[OW-1:0] : '0;
    assign chan_right[g*OW +: OW] = chcfg[g][6] ? shr[OW-1:0] : '0;
  end

  logic signed [MW-1:0] sum_l, sum_r;
  always_comb begin
    sum_l = '0;
    sum_r = '0;
    for (int i = 0; i < NCH; i++) begin
      sum_l = sum_l + MW'($signed(chan_left[i*OW +: OW]));
      sum_r = sum_r + MW'($signed(chan_right[i*OW +: OW]));
    end
  end

  wire signed [MW+6:0] ml = sum_l * $signed({1'b0, total_lvl});
  wire signed [MW+6:0] mr = sum_r * $signed({1'b0, total_lvl});
  wire signed [MW+6:0] ml_s = ml >>> 6;
  wire signed [MW+6:0] mr_s = mr >>> 6;
  assign mix_left = ml_s[MW-1:0];
  assign mix_right = mr_s[MW-1:0];

endmodule

module adpcm_voice_seq_chk #(
  parameter int MW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [5:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic          mem_req,
  input logic [5:0]    chan_playing,
  input logic [5:0]    total_lvl,
  input logic [MW-1:0] mix_left,
  input logic [MW-1:0] mix_right
);

  // R3
  keyon_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 6'h00 && !wr_data[7]) |=>
      ((chan_playing & $past(wr_data[5:0])) == $past(wr_data[5:0])));

  // R3
  rise_only_on_keyon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 6'h00 && !wr_data[7]) |=>
      ((chan_playing & ~$past(chan_playing)) == 6'b0));

  // R4
  dump_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 6'h00 && wr_data[7]) |=>
      ((chan_playing & $past(wr_data[5:0])) == 6'b0));

  // R5
  no_back_to_back_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R11
  silent_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (total_lvl == 6'd0) |-> (mix_left == '0 && mix_right == '0));

endmodule

bind adpcm_voice_seq adpcm_voice_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mem_req(mem_req), .chan_playing(chan_playing), .total_lvl(total_lvl),
  .mix_left(mix_left), .mix_right(mix_right)
);

// File: tb/test_adpcm_voice_seq.sv
module test_adpcm_voice_seq;
  localparam int SH = 4;
  localparam int AW = 16 + SH;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data = '0;
  logic [5:0] chan_playing;
  logic [71:0] chan_left, chan_right;
  logic [14:0] mix_left, mix_right;

  adpcm_voice_seq #(.SHIFT(SH)) i_adpcm_voice_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .chan_playing(chan_playing), .chan_left(chan_left), .chan_right(chan_right),
    .mix_left(mix_left), .mix_right(mix_right)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int mem_byte(int a);
    if (((a >> 6) & 3) == 1) return 8'h77;
    if (((a >> 6) & 3) == 2) return 8'hFF;
    return (a * 37 + (a >> 3) * 11 + 5) & 255;
  endfunction

  always @(posedge clk) if (mem_req) mem_data <= 8'(mem_byte(int'(mem_addr)));

  int m_play[6], m_nib[6], m_byte[6], m_addr[6], m_acc[6], m_idx[6];
  int m_cfg[6], m_st[6], m_en[6];
  int m_tl, m_ch, m_ph, m_fet;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_tick();
    int c, mask, req, code, mag, stp, dlt, v;
    c = m_ch;
    mask = (wr_en && wr_addr == 0) ? int'(wr_data[5:0]) : 0;
    req = (m_ph == 0 && m_play[c] != 0 && m_nib[c] == 0) ? 1 : 0;
    if (m_ph == 1 && m_play[c] != 0 && (m_nib[c] != 0 || m_fet != 0)) begin
      code = (m_nib[c] != 0) ? (m_byte[c] & 15) : (mem_byte(m_addr[c]) >> 4);
      mag = code & 7;
      stp = (4 + m_idx[c] % 4) << (m_idx[c] / 4);
      dlt = (stp * (2 * mag + 1)) / 8;
      m_acc[c] = (code & 8) != 0 ? m_acc[c] - dlt : m_acc[c] + dlt;
      if (m_acc[c] > 2047) m_acc[c] = 2047;
      if (m_acc[c] < -2048) m_acc[c] = -2048;
      m_idx[c] = m_idx[c] + ((mag < 4) ? -1 : 2 * (mag - 3));
      if (m_idx[c] < 0) m_idx[c] = 0;
      if (m_idx[c] > 15) m_idx[c] = 15;
      if (m_nib[c] == 0) begin
        m_byte[c] = mem_byte(m_addr[c]);
        m_nib[c] = 1;
      end else begin
        m_nib[c] = 0;
        if (m_addr[c] == (m_en[c] << SH) + (1 << SH) - 1) m_play[c] = 0;
        else m_addr[c] = (m_addr[c] + 1) & AMASK;
      end
    end
    if (wr_en) begin
      v = int'(wr_addr);
      if (v == 1) m_tl = wr_data & 63;
      else if (v >= 8 && v < 14) m_cfg[v - 8] = wr_data;
      else if (v >= 16 && v < 22) m_st[v - 16] = (m_st[v - 16] & 16'hFF00) | wr_data;
      else if (v >= 24 && v < 30) m_st[v - 24] = (m_st[v - 24] & 16'h00FF) | (wr_data << 8);
      else if (v >= 32 && v < 38) m_en[v - 32] = (m_en[v - 32] & 16'hFF00) | wr_data;
      else if (v >= 40 && v < 46) m_en[v - 40] = (m_en[v - 40] & 16'h00FF) | (wr_data << 8);
    end
    for (int i = 0; i < 6; i++) begin
      if (mask[i]) begin
        if (wr_data[7]) m_play[i] = 0;
        else begin
          m_play[i] = 1; m_nib[i] = 0; m_acc[i] = 0; m_idx[i] = 0;
          m_addr[i] = (m_st[i] << SH) & AMASK;
        end
      end
    end
    m_fet = (req != 0 && mask[c] == 0) ? 1 : 0;
    if (m_ph == 1) m_ch = (m_ch == 5) ? 0 : m_ch + 1;
    m_ph = 1 - m_ph;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 6; i++) begin
      m_play[i] = 0; m_nib[i] = 0; m_byte[i] = 0; m_addr[i] = 0; m_acc[i] = 0;
      m_idx[i] = 0; m_cfg[i] = 0; m_st[i] = 0; m_en[i] = 0;
    end
    m_tl = 0; m_ch = 0; m_ph = 0; m_fet = 0;
  endtask

  initial model_reset();
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_tick();
  end

  function automatic int exp_side(int c, int bitn);
    if (((m_cfg[c] >> bitn) & 1) == 0) return 0;
    return (m_acc[c] * (m_cfg[c] & 31)) >>> 5;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ereq, eplay, sl, sr, al, ar;
      ereq = (m_ph == 0 && m_play[m_ch] != 0 && m_nib[m_ch] == 0) ? 1 : 0;
      check(int'(mem_req) == ereq, "R5 mem_req", int'(mem_req), ereq);
      if (ereq != 0)
        check(int'(mem_addr) == m_addr[m_ch], "R6 mem_addr", int'(mem_addr), m_addr[m_ch]);
      eplay = 0;
      for (int i = 0; i < 6; i++) eplay |= (m_play[i] != 0) << i;
      check(int'(chan_playing) == eplay, "R3/R4/R7/R12 playing", int'(chan_playing), eplay);
      sl = 0; sr = 0;
      for (int i = 0; i < 6; i++) begin
        al = $signed(chan_left[i*12 +: 12]);
        ar = $signed(chan_right[i*12 +: 12]);
        check(al == exp_side(i, 7), "R8/R10 left", al, exp_side(i, 7));
        check(ar == exp_side(i, 6), "R8/R10 right", ar, exp_side(i, 6));
        sl += exp_side(i, 7);
        sr += exp_side(i, 6);
      end
      al = $signed(mix_left);
      ar = $signed(mix_right);
      check(al == ((sl * m_tl) >>> 6), "R2/R11 mix_left", al, (sl * m_tl) >>> 6);
      check(ar == ((sr * m_tl) >>> 6), "R2/R11 mix_right", ar, (sr * m_tl) >>> 6);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic voice(int v, int cfg, int st, int en);
    wr(8 + v, cfg);
    wr(16 + v, st & 255); wr(24 + v, st >> 8);
    wr(32 + v, en & 255); wr(40 + v, en >> 8);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(chan_playing == 0, "R1 playing", int'(chan_playing), 0);
    check(mem_req == 0, "R1 mem_req", int'(mem_req), 0);
    check(mix_left == 0 && mix_right == 0, "R1 mix", int'(mix_left), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    wr(1, 8'h30);
    voice(0, 8'hDF, 4, 7);
    voice(1, 8'hDF, 8, 11);
    voice(2, 8'h9A, 0, 0);
    voice(3, 8'h55, 12, 13);
    voice(4, 8'hC7, 3, 3);
    voice(5, 8'h8F, 14, 15);
    // R2: writes outside the map
    wr(8'h0E, 8'hFF); wr(8'h16, 8'hFF); wr(8'h2F, 8'hFF);
    wr(8'h31, 8'h00); wr(8'h38, 8'h00); wr(8'h09 + 8'h30, 8'h00);
    wr(0, 8'h3F);
    check(chan_playing == 6'h3F, "R3 keyon all", int'(chan_playing), 63);
    repeat (1700) @(negedge clk);
    // R7
    check(chan_playing[0] == 0 && chan_playing[2] == 0, "R7 stopped", int'(chan_playing), 0);
    // R9
    check($signed(chan_left[11:0]) == 1983, "R9 clamp high", $signed(chan_left[11:0]), 1983);
    check($signed(chan_left[23:12]) == -1984, "R9 clamp low", $signed(chan_left[23:12]), -1984);
    // R2: mix still uses level 0x30 despite aliased writes
    check(mix_left != 0, "R2 level kept", int'(mix_left), 1);
    wr(0, 8'h3C);
    repeat (50) @(negedge clk);
    wr(0, 8'h94);
    // R4
    check(chan_playing[2] == 0 && chan_playing[4] == 0, "R4 dump", int'(chan_playing), 0);
    // R12: key-on voice 3 at every slot phase
    for (int k = 0; k < 26; k++) begin
      repeat (k % 13 + 11) @(negedge clk);
      wr(0, (k % 2) ? 8'h08 : 8'h0A);
    end
    repeat (300) @(negedge clk);
    wr(1, 0);
    @(negedge clk);
    // R11
    check(mix_left == 0 && mix_right == 0, "R11 zero level", int'(mix_left), 0);
    wr(0, 8'hBF);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule